// File: doc/BRIEF.md
# Vertical Sync Loss Guard

This block watches the vertical sync input of a display timing generator and measures, in units of the horizontal period, how long it has been since the last vertical sync edge. If no edge arrives within a limit set by the selected TV standard, it raises a no-signal flag. It then hands the vertical reference over to an auxiliary line counter that runs freely, so the panel keeps getting field pulses and stays AC driven while the picture source is gone.

While the flag is up, the block stops the phase comparator output from being driven, lets the horizontal divider run free, and forces wide (16:9) mode back to normal 4:3. The change to free running waits for a field boundary of the auxiliary counter. The return to real sync is also aligned to a field: the first vsync edge clears the flag, and the vertical reference follows real sync again from the next vsync edge.

Every pin is a plain control or status level or a single-cycle strobe. The block carries no data stream, so there is no handshake and no back-pressure.

Top module: `vsync_loss_guard`

## Requirements
- R1: While `rst_n` is low, every output (`no_sig`, `vref`, `wide_en`, `pd_oe`, `hfree`) is 0.
- R2: While the reference is locked to real sync, each rising edge of `vsync` produces exactly one `vref` pulse, one cycle long, visible in the cycle after the first high cycle of `vsync`.
- R3: `no_sig` rises on the N-th `line_stb` after the last `vsync` rising edge, and not earlier. N is 301 with `pal_sel`=0 (525-line standard) and 360 with `pal_sel`=1 (625-line standard).
- R4: While `no_sig` is 1, `pd_oe` is 0 (phase comparator output released to high impedance) and `hfree` is 1. Otherwise `pd_oe` is 1 (from the first cycle after reset) and `hfree` is 0.
- R5: `wide_en` equals `wide_req` AND NOT `no_sig`, registered on the same edge that updates `no_sig`.
- R6: The auxiliary counter wraps every P line strobes, with P = 269 when `pal_sel`=0 and 321 when `pal_sel`=1, counted from the last accepted `vsync` edge. Once `no_sig` is set, each wrap produces a `vref` pulse. The first such pulse comes at the first wrap after the flag is set (strobe 538 or 642 after the last edge).
- R7: An auxiliary wrap that occurs while `no_sig` is 0 and the reference is locked produces no `vref`.
- R8: The first `vsync` rising edge during no-signal clears `no_sig` and restarts the timeout count. If free running had already started, that edge produces no `vref` and the auxiliary counter keeps its phase.
- R9: After recovery from free running, free-run `vref` pulses continue on auxiliary wraps until the next `vsync` edge. That edge produces a `vref` pulse, resets the auxiliary counter and returns the reference to real sync.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low system clear, asynchronous |
| line_stb | input | 1 | One-cycle pulse per horizontal period |
| vsync | input | 1 | Vertical sync, active high, rising edge used |
| pal_sel | input | 1 | 0: 525-line limits, 1: 625-line limits |
| wide_req | input | 1 | Request for 16:9 wide mode |
| no_sig | output | 1 | Vertical sync lost |
| vref | output | 1 | One-cycle vertical reference pulse |
| wide_en | output | 1 | Effective wide-mode enable |
| pd_oe | output | 1 | Drive enable of the phase comparator output |
| hfree | output | 1 | Horizontal divider free-run request |

## Verification
The assertions assume the following about the inputs:
- `line_stb` is a single-cycle pulse.
- A `vsync` rising edge never falls in the same cycle as a line strobe.
- `vsync` pulses are separated by at least a few cycles.
- `pal_sel` is held steady between resets.

The stimulus keeps to these limits. It spaces line strobes four clocks apart, places every vsync pulse in the idle cycles between two strobes, and changes `pal_sel` only while reset is held. Each standard is swept strobe by strobe across the timeout, several free-run fields, recovery, realignment and a second timeout.

// File: rtl/vlg_pkg.sv
package vlg_pkg;
  typedef enum logic {STD_525 = 1'b0, STD_625 = 1'b1} tv_std_e;

  function automatic int pick(input tv_std_e s, input int v525, input int v625);
    return (s == STD_625) ? v625 : v525;
  endfunction
endpackage

// File: rtl/vlg_edge.sv
module vlg_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic level,
  output logic rise
);
  logic level_q;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) level_q <= 1'b0;
    else        level_q <= level;
  assign rise = level & ~level_q;
endmodule

// File: rtl/vlg_timeout.sv
module vlg_timeout
  import vlg_pkg::*;
#(
  parameter int CW    = 9,
  parameter int LIM_A = 301,
  parameter int LIM_B = 360
) (
  input  logic    clk,
  input  logic    rst_n,
  input  tv_std_e std,
  input  logic    line_stb,
  input  logic    restart,
  output logic    fire
);
  logic [CW-1:0] cnt;
  logic [CW-1:0] last;
  assign last = CW'(pick(std, LIM_A, LIM_B) - 1);
  assign fire = line_stb & ~restart & (cnt == last);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                         cnt <= '0;
    else if (restart)                   cnt <= '0;
    else if (line_stb && cnt != last)   cnt <= cnt + 1'b1;
endmodule

// File: rtl/vlg_auxcnt.sv
module vlg_auxcnt
  import vlg_pkg::*;
#(
  parameter int CW    = 9,
  parameter int PER_A = 269,
  parameter int PER_B = 321
) (
  input  logic    clk,
  input  logic    rst_n,
  input  tv_std_e std,
  input  logic    line_stb,
  input  logic    realign,
  output logic    wrap
);
  logic [CW-1:0] cnt;
  logic [CW-1:0] last;
  assign last = CW'(pick(std, PER_A, PER_B) - 1);
  assign wrap = line_stb & ~realign & (cnt == last);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)        cnt <= '0;
    else if (realign)  cnt <= '0;
    else if (line_stb) cnt <= (cnt == last) ? '0 : cnt + 1'b1;
endmodule

// File: rtl/vsync_loss_guard.sv
module vsync_loss_guard
  import vlg_pkg::*;
#(
  parameter int TMO_525  = 301,
  parameter int TMO_625  = 360,
  parameter int FREE_525 = 269,
  parameter int FREE_625 = 321
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_stb,
  input  logic vsync,
  input  logic pal_sel,
  input  logic wide_req,
  output logic no_sig,
  output logic vref,
  output logic wide_en,
  output logic pd_oe,
  output logic hfree
);
  localparam int MAXV = (TMO_625 > TMO_525) ? TMO_625 : TMO_525;
  localparam int CW   = $clog2(MAXV + 1);

  tv_std_e std;
  logic    vs_rise, tmo_fire, aux_wrap, real_take, ns_next, free_run;

  assign std = tv_std_e'(pal_sel);

  vlg_edge u_edge (.clk(clk), .rst_n(rst_n), .level(vsync), .rise(vs_rise));

  vlg_timeout #(.CW(CW), .LIM_A(TMO_525), .LIM_B(TMO_625)) u_tmo (
    .clk(clk), .rst_n(rst_n), .std(std), .line_stb(line_stb),
    .restart(vs_rise), .fire(tmo_fire));

  vlg_auxcnt #(.CW(CW), .PER_A(FREE_525), .PER_B(FREE_625)) u_aux (
    .clk(clk), .rst_n(rst_n), .std(std), .line_stb(line_stb),
    .realign(real_take), .wrap(aux_wrap));

  // A vsync edge is taken as a real field start unless free running is
  // active and the flag is still set (that edge only recovers the flag).
  assign real_take = vs_rise & (~free_run | ~no_sig);
  assign ns_next   = vs_rise ? 1'b0 : (no_sig | tmo_fire);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      no_sig   <= 1'b0;
      free_run <= 1'b0;
      vref     <= 1'b0;
      wide_en  <= 1'b0;
      pd_oe    <= 1'b0;
    end else begin
      no_sig  <= ns_next;
      vref    <= real_take | (aux_wrap & (free_run | no_sig));
      wide_en <= wide_req & ~ns_next;
      pd_oe   <= ~ns_next;
      if (real_take)              free_run <= 1'b0;
      else if (aux_wrap & no_sig) free_run <= 1'b1;
    end

  assign hfree = no_sig;
endmodule

// File: rtl/vsync_loss_guard_chk.sv
module vsync_loss_guard_chk (
  input logic clk,
  input logic rst_n,
  input logic line_stb,
  input logic vsync,
  input logic wide_req,
  input logic no_sig,
  input logic vref,
  input logic wide_en,
  input logic pd_oe,
  input logic hfree
);
  assert_vref_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    vref |=> !vref);
  assert_lost_on_line_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(no_sig) |-> $past(line_stb));
  assert_pd_released_R4: assert property (@(posedge clk) disable iff (!rst_n)
    no_sig |-> (!pd_oe && hfree));
  assert_wide_forced_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wide_en |-> (!no_sig && $past(wide_req)));
  assert_free_pulse_on_line_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (vref && no_sig) |-> $past(line_stb));
  assert_recover_on_edge_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(no_sig) |-> ($past(vsync) && !$past(vsync, 2)));
endmodule

bind vsync_loss_guard vsync_loss_guard_chk u_chk (.*);

// File: tb/vsync_loss_guard_tb.sv
`timescale 1ns/1ps
module vsync_loss_guard_tb;
  logic clk = 1'b0, rst_n = 1'b0, line_stb = 1'b0, vsync = 1'b0;
  logic pal_sel = 1'b0, wide_req = 1'b0;
  logic no_sig, vref, wide_en, pd_oe, hfree;
  int n_cmp = 0, n_bad = 0, cyc = 0;

  always #4 clk = ~clk;

  vsync_loss_guard u_dut (.*);

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: got running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic chk(input string req, input string what, input logic got, input logic exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %b expected %b (t=%0t)", req, what, got, exp, $time);
    end
  endtask

  task automatic check_all(input string rq_v, input logic ev, input logic ens, input logic wr);
    chk(rq_v, "vref", vref, ev);
    chk("R3", "no_sig", no_sig, ens);
    chk("R4", "pd_oe", pd_oe, ~ens);
    chk("R4", "hfree", hfree, ens);
    chk("R5", "wide_en", wide_en, wr & ~ens);
  endtask

  // one line strobe, sampled one clock later, then two idle clocks
  task automatic strobe(input logic wr, input string rq_v, input logic ev, input logic ens);
    @(negedge clk); line_stb = 1'b1; wide_req = wr;
    @(negedge clk); line_stb = 1'b0;
    check_all(rq_v, ev, ens, wr);
    repeat (2) @(negedge clk);
  endtask

  task automatic vs_pulse(input string rq, input logic ev);
    @(negedge clk); vsync = 1'b1;
    @(negedge clk);
    chk(rq, "vref at edge", vref, ev);
    chk(rq, "no_sig at edge", no_sig, 1'b0);
    chk(rq, "pd_oe at edge", pd_oe, 1'b1);
    vsync = 1'b0;
    @(negedge clk);
    chk("R2", "vref one cycle", vref, 1'b0);
  endtask

  initial begin
    for (int s = 0; s < 2; s++) begin
      int per, tmo, kk;
      per = (s == 1) ? 321 : 269;
      tmo = (s == 1) ? 360 : 301;
      rst_n = 1'b0; pal_sel = s[0];
      repeat (3) @(negedge clk);
      chk("R1", "no_sig in clear", no_sig, 1'b0);
      chk("R1", "vref in clear", vref, 1'b0);
      chk("R1", "wide_en in clear", wide_en, 1'b0);
      chk("R1", "pd_oe in clear", pd_oe, 1'b0);
      chk("R1", "hfree in clear", hfree, 1'b0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R4", "pd_oe after clear", pd_oe, 1'b1);

      vs_pulse("R2", 1'b1);
      kk = 3 * per + 5;
      for (int k = 1; k <= kk; k++) begin
        logic wr; wr = k[2];
        if ((k % per == 0) && k <= tmo)
          strobe(wr, "R7", 1'b0, k >= tmo);
        else
          strobe(wr, "R6", (k % per == 0) && (k > tmo), k >= tmo);
      end

      vs_pulse("R8", 1'b0);
      for (int j = 1; j <= per + 10; j++)
        strobe(j[1], "R9", ((kk + j) % per) == 0, 1'b0);

      vs_pulse("R9", 1'b1);
      for (int j = 1; j <= 2 * per + 2; j++)
        strobe(j[3], (j <= tmo) ? "R7" : "R6", (j % per == 0) && (j > tmo), j >= tmo);
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule